// File: doc/BRIEF.md
# Dual-Image Fallback Configuration Loader

This block sequences the loading of a programmable device's configuration image from a byte-wide parallel flash memory after power-up or a board reset. It drives a passive-parallel configuration port. It opens each load with a low pulse on the config-start line and waits for the target's status line to rise. It then streams the image one byte at a time, moving each byte from the flash read port to the target with a one-clock strobe.

Two images sit at fixed offsets in flash. The user image is tried first. If that load fails, the loader restarts the target and loads the factory image from the second region. A load fails when the target drops its status line, when the status line never rises, or when done has not appeared shortly after the region's last byte. A strap input skips the user image and goes straight to the factory image. If the factory load also fails, the loader stops in an error state until the next reset. When a load succeeds, it reports done and which image was used.

Top module: `dual_image_loader`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block holds `cfg_start_n` high, `cfg_strobe` low, `load_done` low and `load_error` low. A new load sequence starts after every reset.
- R2: Each load attempt begins with `cfg_start_n` low for exactly PULSE_CLKS clocks (default 2). No strobe is issued until `cfg_status` has been seen high.
- R3: With `factory_strap` low, the first attempt reads the user region at USER_BASE (default 0x080000). Byte i of an attempt is read from the region base plus i.
- R4: With `factory_strap` high, only one attempt is made, and it reads the factory region at FACT_BASE (default 0x0C0000).
- R5: Each byte takes three clocks: the address is shown, the flash byte is latched, and then `cfg_strobe` is high for one clock. During the strobe, `cfg_data` carries the flash byte at the address shown in that byte's slot.
- R6: If `cfg_status` is low during a transfer while `cfg_done` is low, the attempt fails at once, and no further byte of that attempt is strobed.
- R7: If `cfg_done` is still low TAIL_CLKS (default 16) clocks after the region's last byte, the attempt fails. The next start pulse begins TAIL_CLKS+1 clocks after the last strobe.
- R8: When `cfg_done` is seen high during a transfer, `load_done` rises and stays high until reset. `image_sel` reports the image that was loaded (0 = user, 1 = factory). No more strobes or start pulses follow.
- R9: A failed user attempt leads to one factory attempt. A failed factory attempt raises `load_error`, which stays high until reset with `image_sel` = 1.
- R10: If `cfg_status` stays low for STATUS_WAIT_CLKS clocks after the start pulse, the attempt fails and no byte is strobed.
- R11: If `cfg_done` is high and `cfg_status` is low in the same clock, the attempt counts as a success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low board reset; restarts loading |
| factory_strap | input | 1 | High: skip the user image, load the factory image |
| flash_addr | output | ADDR_W | Flash byte address |
| flash_data | input | DATA_W | Flash read data, valid one clock after the address |
| cfg_start_n | output | 1 | Active-low configuration start pulse |
| cfg_data | output | DATA_W | Configuration data byte |
| cfg_strobe | output | 1 | One-clock data strobe |
| cfg_status | input | 1 | Target ready/healthy status (high = good) |
| cfg_done | input | 1 | Target reports configuration complete |
| load_done | output | 1 | Load succeeded |
| image_sel | output | 1 | Image attempted or loaded: 0 user, 1 factory |
| load_error | output | 1 | Both images failed |

## Verification
The assertions assume that the flash returns the byte for the address shown within one clock. They also assume that `factory_strap` is steady while reset is released, and that the target lowers status and done whenever a start pulse arrives. The bench's target model follows these rules. It clears its status and done during every start pulse and raises status a chosen number of clocks later. It asserts done or drops status only right after a counted strobe, and the flash model is a combinational function of the address. Random cases vary the strap, the status delay, the byte count at which done appears (including the last byte of the region) and a byte count at which status drops. Directed cases cover the exact fallback gap, the status timeout and a done that coincides with a status drop.

// File: rtl/cfgld_pkg.sv
// Shared types for the dual-image configuration loader.
// Assumes nothing beyond a SystemVerilog 2017 compiler.
package cfgld_pkg;

    // Sequencer states; the byte loop is ADDR -> LATCH -> STROBE.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PULSE,
        ST_WAIT,
        ST_ADDR,
        ST_LATCH,
        ST_STROBE,
        ST_TAIL,
        ST_OK,
        ST_ERR
    } ld_state_t;

    // Image selector; its encoding is visible on the image_sel port.
    typedef enum logic {
        IMG_USER    = 1'b0,
        IMG_FACTORY = 1'b1
    } img_t;

endpackage

// File: rtl/cfgld_timer.sv
// Run-length timer: counts clocks while run is high, clears when run
// drops. hit is high in the LIMIT-th consecutive clock of run.
// Assumes LIMIT >= 2. The counter saturates at LIMIT-1.
module cfgld_timer #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic hit
);
    localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    // Count consecutive clocks of run, saturating at the last value.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign hit = run && (cnt == LAST);
endmodule

// File: rtl/cfgld_addr_gen.sv
// Flash address generator: a byte offset within the selected region,
// added to that region's fixed base. last flags the region's final byte.
// Assumes REGION_BYTES >= 2 and that both regions fit in ADDR_W bits.
module cfgld_addr_gen
    import cfgld_pkg::*;
#(
    parameter int unsigned ADDR_W       = 20,
    parameter int unsigned USER_BASE    = 32'h0008_0000,
    parameter int unsigned FACT_BASE    = 32'h000C_0000,
    parameter int unsigned REGION_BYTES = 32'h0004_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              advance,
    input  img_t              img,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    localparam int unsigned OFS_W = $clog2(REGION_BYTES);
    localparam logic [OFS_W-1:0] LAST_OFS = OFS_W'(REGION_BYTES - 1);
    localparam logic [ADDR_W-1:0] UBASE = ADDR_W'(USER_BASE);
    localparam logic [ADDR_W-1:0] FBASE = ADDR_W'(FACT_BASE);

    logic [OFS_W-1:0]  offset;
    logic [ADDR_W-1:0] base;

    // Byte offset: cleared at the start of each attempt, stepped per byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            offset <= '0;
        end else if (advance) begin
            offset <= offset + 1'b1;
        end
    end

    // Region base chosen by the image being loaded.
    always_comb begin
        base = (img == IMG_FACTORY) ? FBASE : UBASE;
    end

    assign addr = base + ADDR_W'(offset);
    assign last = (offset == LAST_OFS);
endmodule

// File: rtl/cfgld_seq.sv
// Load sequencer. It picks the image, pulses start, waits for status,
// runs the three-clock byte loop and judges success or failure. After a
// user failure it retries once with the factory image.
// Assumes timer hits and the last-byte flag come from sibling modules.
module cfgld_seq
    import cfgld_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      strap,
    input  logic      cfg_status,
    input  logic      cfg_done,
    input  logic      pulse_hit,
    input  logic      wait_hit,
    input  logic      tail_hit,
    input  logic      last_byte,
    output ld_state_t state,
    output img_t      img,
    output logic      addr_clear,
    output logic      addr_adv,
    output logic      latch_en
);
    ld_state_t nxt;
    img_t      img_nxt;
    logic      fail;

    // State and image registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            img   <= IMG_USER;
        end else begin
            state <= nxt;
            img   <= img_nxt;
        end
    end

    // Next-state logic; a failure is resolved in one place below.
    always_comb begin
        nxt        = state;
        img_nxt    = img;
        addr_clear = 1'b0;
        addr_adv   = 1'b0;
        latch_en   = 1'b0;
        fail       = 1'b0;
        unique case (state)
            ST_IDLE: begin
                img_nxt    = strap ? IMG_FACTORY : IMG_USER;
                addr_clear = 1'b1;
                nxt        = ST_PULSE;
            end
            ST_PULSE: begin
                addr_clear = 1'b1;
                if (pulse_hit) nxt = ST_WAIT;
            end
            ST_WAIT: begin
                if (cfg_status)    nxt  = ST_ADDR;
                else if (wait_hit) fail = 1'b1;
            end
            ST_ADDR, ST_LATCH, ST_STROBE: begin
                if (cfg_done) begin
                    nxt = ST_OK;
                end else if (!cfg_status) begin
                    fail = 1'b1;
                end else if (state == ST_ADDR) begin
                    nxt = ST_LATCH;
                end else if (state == ST_LATCH) begin
                    latch_en = 1'b1;
                    nxt      = ST_STROBE;
                end else if (last_byte) begin
                    nxt = ST_TAIL;
                end else begin
                    addr_adv = 1'b1;
                    nxt      = ST_ADDR;
                end
            end
            ST_TAIL: begin
                if (cfg_done)         nxt  = ST_OK;
                else if (!cfg_status) fail = 1'b1;
                else if (tail_hit)    fail = 1'b1;
            end
            ST_OK:   nxt = ST_OK;
            ST_ERR:  nxt = ST_ERR;
            default: nxt = ST_IDLE;
        endcase
        if (fail) begin
            if (img == IMG_USER) begin
                img_nxt = IMG_FACTORY;
                nxt     = ST_PULSE;
            end else begin
                nxt = ST_ERR;
            end
        end
    end
endmodule

// File: rtl/dual_image_loader.sv
// Top level of the dual-image configuration loader. It ties the
// sequencer to the address generator, the three phase timers and the
// data register, and decodes the port outputs from the state.
// Assumes flash_data is valid one clock after flash_addr changes.
module dual_image_loader
    import cfgld_pkg::*;
#(
    parameter int unsigned ADDR_W           = 20,
    parameter int unsigned DATA_W           = 8,
    parameter int unsigned USER_BASE        = 32'h0008_0000,
    parameter int unsigned FACT_BASE        = 32'h000C_0000,
    parameter int unsigned REGION_BYTES     = 32'h0004_0000,
    parameter int unsigned PULSE_CLKS       = 2,
    parameter int unsigned STATUS_WAIT_CLKS = 4096,
    parameter int unsigned TAIL_CLKS        = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              factory_strap,
    output logic [ADDR_W-1:0] flash_addr,
    input  logic [DATA_W-1:0] flash_data,
    output logic              cfg_start_n,
    output logic [DATA_W-1:0] cfg_data,
    output logic              cfg_strobe,
    input  logic              cfg_status,
    input  logic              cfg_done,
    output logic              load_done,
    output logic              image_sel,
    output logic              load_error
);
    ld_state_t         state;
    img_t              img;
    logic              addr_clear, addr_adv, latch_en, last_byte;
    logic              pulse_hit, wait_hit, tail_hit;
    logic [DATA_W-1:0] data_q;

    cfgld_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap      (factory_strap),
        .cfg_status (cfg_status),
        .cfg_done   (cfg_done),
        .pulse_hit  (pulse_hit),
        .wait_hit   (wait_hit),
        .tail_hit   (tail_hit),
        .last_byte  (last_byte),
        .state      (state),
        .img        (img),
        .addr_clear (addr_clear),
        .addr_adv   (addr_adv),
        .latch_en   (latch_en)
    );

    cfgld_addr_gen #(
        .ADDR_W       (ADDR_W),
        .USER_BASE    (USER_BASE),
        .FACT_BASE    (FACT_BASE),
        .REGION_BYTES (REGION_BYTES)
    ) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (addr_clear),
        .advance (addr_adv),
        .img     (img),
        .addr    (flash_addr),
        .last    (last_byte)
    );

    cfgld_timer #(.LIMIT(PULSE_CLKS)) u_pulse_tmr (
        .clk (clk), .rst_n (rst_n), .run (state == ST_PULSE), .hit (pulse_hit)
    );

    cfgld_timer #(.LIMIT(STATUS_WAIT_CLKS)) u_wait_tmr (
        .clk (clk), .rst_n (rst_n), .run (state == ST_WAIT), .hit (wait_hit)
    );

    cfgld_timer #(.LIMIT(TAIL_CLKS)) u_tail_tmr (
        .clk (clk), .rst_n (rst_n), .run (state == ST_TAIL), .hit (tail_hit)
    );

    // Data register: captures the flash byte in the latch phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (latch_en) begin
            data_q <= flash_data;
        end
    end

    // Port decode from the sequencer state.
    always_comb begin
        cfg_start_n = (state != ST_PULSE);
        cfg_strobe  = (state == ST_STROBE);
        cfg_data    = data_q;
        load_done   = (state == ST_OK);
        load_error  = (state == ST_ERR);
        image_sel   = (img == IMG_FACTORY);
    end
endmodule

// File: rtl/cfgld_chk.sv
// Protocol checker for the loader's ports, bound to every instance.
// Assumes synchronous active-low reset on rst_n.
module cfgld_chk #(
    parameter int unsigned ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_start_n,
    input logic              cfg_strobe,
    input logic              load_done,
    input logic              load_error,
    input logic              image_sel,
    input logic [ADDR_W-1:0] flash_addr
);
    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> load_done);
    // R9
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_error |=> load_error);
    // R9
    err_factory_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_error |-> image_sel);
    // R8
    result_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load_done, load_error}));
    // R8
    quiet_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_done || load_error) |-> (!cfg_strobe && cfg_start_n));
    // R5
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_strobe |=> !cfg_strobe);
    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_strobe |-> $stable(flash_addr));
    // R2
    pulse_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_start_n) |=> !cfg_start_n);
    // R2
    no_strobe_in_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_start_n |-> !cfg_strobe);
endmodule

bind dual_image_loader cfgld_chk #(.ADDR_W(ADDR_W)) u_cfgld_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_start_n (cfg_start_n),
    .cfg_strobe  (cfg_strobe),
    .load_done   (load_done),
    .load_error  (load_error),
    .image_sel   (image_sel),
    .flash_addr  (flash_addr)
);

// File: tb/tb_dual_image_loader.sv
module tb_dual_image_loader;
    localparam int RB = 32;      // region bytes
    localparam int WL = 40;      // status wait limit
    localparam int TL = 16;      // tail clocks
    localparam int NEVER = 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        factory_strap = 1'b0;
    logic [19:0] flash_addr;
    logic [7:0]  flash_data;
    logic        cfg_start_n, cfg_strobe, load_done, image_sel, load_error;
    logic [7:0]  cfg_data;
    logic        cfg_status = 1'b0;
    logic        cfg_done = 1'b0;

    int vectors = 0, errors = 0, cyc = 0;

    always #4 clk = ~clk;

    dual_image_loader #(
        .REGION_BYTES(RB), .STATUS_WAIT_CLKS(WL), .TAIL_CLKS(TL)
    ) dut (
        .clk(clk), .rst_n(rst_n), .factory_strap(factory_strap),
        .flash_addr(flash_addr), .flash_data(flash_data),
        .cfg_start_n(cfg_start_n), .cfg_data(cfg_data), .cfg_strobe(cfg_strobe),
        .cfg_status(cfg_status), .cfg_done(cfg_done),
        .load_done(load_done), .image_sel(image_sel), .load_error(load_error)
    );

    function automatic logic [7:0] pat(input logic [19:0] a);
        return (a[7:0] * 8'd5) ^ a[19:12] ^ 8'h3C;
    endfunction

    function automatic logic [19:0] base_of(input bit fact);
        return fact ? 20'hC0000 : 20'h80000;
    endfunction

    assign flash_data = pat(flash_addr);

    // target model configuration per attempt
    int  tw[3], tdrop[3], tdone[3];
    bit  eimg[3];
    int  att, pl, wc, nstr[3], last_str, gap;
    bit  waiting, raised[3], prev_start;
    int  data_err, space_err, pulse_err, early_err;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Target model and monitor, acting away from the active edge.
    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            att = -1; cfg_status = 0; cfg_done = 0; prev_start = 1; waiting = 0;
        end else begin
            if (!cfg_start_n) begin
                if (prev_start) begin
                    att++;
                    gap = cyc - last_str;
                    pl = 0;
                    if (att < 3) begin nstr[att] = 0; raised[att] = 0; end
                end
                pl++;
                cfg_status = 0; cfg_done = 0; waiting = 1; wc = 0;
            end else begin
                if (!prev_start && pl != 2) pulse_err++;
                if (waiting && att >= 0 && att < 3) begin
                    if (wc >= tw[att]) begin
                        cfg_status = 1; waiting = 0; raised[att] = 1;
                    end else wc++;
                end
            end
            if (cfg_strobe) begin
                if (att < 0 || att > 1 || !raised[att]) early_err++;
                else begin
                    nstr[att]++;
                    if (cfg_data !== pat(base_of(eimg[att]) + 20'(nstr[att] - 1))) data_err++;
                    if (nstr[att] > 1 && cyc - last_str != 3) space_err++;
                    if (nstr[att] == tdone[att]) cfg_done = 1;
                    if (nstr[att] == tdrop[att]) cfg_status = 0;
                end
                last_str = cyc;
            end
            prev_start = cfg_start_n;
        end
    end

    // Expected outcome of one attempt: success flag and bytes strobed.
    function automatic void predict(input int w, input int drop, input int done,
                                    output bit ok, output int bytes);
        int de, dr;
        de = (done >= 1 && done <= RB) ? done : NEVER;
        dr = (drop >= 1 && drop <= RB) ? drop : NEVER;
        if (w >= WL) begin ok = 0; bytes = 0; end
        else if (de != NEVER && de <= dr) begin ok = 1; bytes = de; end
        else begin ok = 0; bytes = (dr < RB) ? dr : RB; end
    endfunction

    task automatic run_case(input bit strap, input int uw, ud, un,
                            input int fw, fd, fn, input int exp_gap);
        bit uok, fok, exp_done, exp_sel;
        int ub, fb, n_att, t;
        rst_n = 0;
        factory_strap = strap;
        data_err = 0; space_err = 0; pulse_err = 0; early_err = 0;
        for (int i = 0; i < 3; i++) begin tw[i] = NEVER; tdrop[i] = 0; tdone[i] = 0; eimg[i] = 1; end
        predict(uw, ud, un, uok, ub);
        predict(fw, fd, fn, fok, fb);
        if (strap) begin
            tw[0] = fw; tdrop[0] = fd; tdone[0] = fn; eimg[0] = 1;
            n_att = 1; exp_done = fok; exp_sel = 1;
        end else begin
            tw[0] = uw; tdrop[0] = ud; tdone[0] = un; eimg[0] = 0;
            tw[1] = fw; tdrop[1] = fd; tdone[1] = fn; eimg[1] = 1;
            n_att = uok ? 1 : 2; exp_done = uok ? 1'b1 : fok; exp_sel = !uok;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        t = 0;
        while (!load_done && !load_error && t < 3000) begin @(negedge clk); t++; end
        check(t < 3000, "R8/R9 completion", t, 3000);
        repeat (40) @(negedge clk);
        // R8 R9 R11 outcome and image report
        check(load_done == exp_done, "R8 load_done", int'(load_done), int'(exp_done));
        check(load_error == !exp_done, "R9 load_error", int'(load_error), int'(!exp_done));
        check(image_sel == exp_sel, "R8 image_sel", int'(image_sel), int'(exp_sel));
        // R3 R4 attempt count and image order
        check(att + 1 == n_att, strap ? "R4 attempts" : "R3 attempts", att + 1, n_att);
        // R6 R7 R10 bytes strobed per attempt
        if (strap) check(nstr[0] == fb, "R4/R6 factory bytes", nstr[0], fb);
        else begin
            check(nstr[0] == ub, "R6/R10 user bytes", nstr[0], ub);
            if (!uok) check(nstr[1] == fb, "R9 factory bytes", nstr[1], fb);
        end
        // R5 data, address order and byte spacing
        check(data_err == 0, "R5 data", data_err, 0);
        check(space_err == 0, "R5 spacing", space_err, 0);
        // R2 start pulse width and no early strobe
        check(pulse_err == 0 && early_err == 0, "R2 pulse", pulse_err + early_err, 0);
        if (exp_gap > 0) check(gap == exp_gap, "R7 fallback gap", gap, exp_gap);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(cfg_start_n && !cfg_strobe && !load_done && !load_error, "R1 reset",
              {cfg_start_n, cfg_strobe, load_done, load_error}, 4'b1000);
        // R3 R8: good user image
        run_case(0, 3, 0, RB - 2, 2, 0, RB - 1, 0);
        // R4: strap skips a good user image
        run_case(1, 3, 0, RB - 2, 5, 0, RB - 3, 0);
        // R7: user never reports done, fallback gap TL+1
        run_case(0, 1, 0, 0, 2, 0, RB, TL + 1);
        // R6 R9: both images drop status -> error
        run_case(0, 0, 7, 0, 4, 12, 0, 0);
        // R10: status never rises on user
        run_case(0, NEVER, 0, 0, 1, 0, 9, 0);
        // R11: done and status drop in the same cycle
        run_case(0, 2, 10, 10, 1, 0, 5, 0);
        // R9: strap and failing factory
        run_case(1, 0, 0, 5, 0, 0, 0, 0);
        // R1: reset mid-load restarts from the user image
        rst_n = 0; factory_strap = 0;
        repeat (2) @(negedge clk); rst_n = 1;
        repeat (50) @(negedge clk);
        run_case(0, 6, 0, RB, 0, 0, 4, 0);
        for (int k = 0; k < 12; k++) begin
            int v[6];
            for (int j = 0; j < 2; j++) begin
                v[3*j]   = $urandom % 15;
                v[3*j+1] = ($urandom % 3 == 0) ? 1 + $urandom % RB : 0;
                v[3*j+2] = ($urandom % 4 == 0) ? 0 : RB - ($urandom % 6);
            end
            run_case($urandom % 4 == 0, v[0], v[1], v[2], v[3], v[4], v[5], 0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        vectors++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule